// File: doc/BRIEF.md
# Fractional-Rate PWM Generator

This block produces one pulse-width-modulated output whose rate is set by a phase accumulator instead of a terminal count. Every clock the accumulator grows by a programmable base-unit increment. Its top eight bits act as an 8-bit phase counter. An output period ends, and the next begins, each time that counter wraps from 255 back to 0. The output is high while the phase is at or above an 8-bit on-time threshold. This threshold is stored inverted: a small value gives a long high time.

All control goes through a single 32-bit register on a plain memory-mapped port with a write strobe, a read strobe and read data. Software stages a new increment and threshold, then raises a request bit. The generator copies the staged pair into its working copy only at the start of the next output period, and clears the request bit itself. Software can poll that bit to learn when the change has taken effect. A write that arrives while a request is still pending cannot disturb the generator. Its increment and threshold are dropped and a sticky error flag is raised instead.

Top module: `pwm_fracgen`

## Requirements
- R1: After reset the register reads as all zeros and `pwm_out` is low.
- R2: Register fields: bit 31 enable, bit 30 update request, bit 29 sticky error (read only), bits 8 upward (BW bits wide) base-unit increment, bits 7:0 on-time threshold. A read returns the staged increment and threshold.
- R3: While enabled, the accumulator (BW+8 bits) adds the active increment every clock. When the increment divides 2^(BW+8), an output period lasts 2^(BW+8)/increment clocks.
- R4: The output is high while the phase (the top 8 accumulator bits) is greater than or equal to the active threshold. High time is period×(256−threshold)/256, and a threshold of 0 keeps the output high.
- R5: Writing staged values without the request bit leaves the running output unchanged.
- R6: The request bit reads 1 from the accepted write until the next period start. At that start the hardware clears it and loads the staged pair into the active copy.
- R7: While a request is pending, a write leaves the staged increment and threshold and the request unchanged and sets the error flag. The pending update still completes normally afterwards.
- R8: A register read clears the error flag, unless a new error occurs in the same cycle.
- R9: With enable at 0 the output is low and the accumulator stays at zero, and a pending request stays pending. The first enabled clock starts a fresh period at phase 0, and that start applies any pending update.
- R10: A staged increment of 0 is applied as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe (clears the error flag) |
| rd_data | output | 32 | Register contents |
| pwm_out | output | 1 | PWM output |

## Verification
The assertions check on every cycle the rules that hold between registers:
- the active copy changes only at a period start that carries a pending request;
- a write rejected while a request is pending leaves the staged copy alone and raises the error flag;
- reads clear that flag;
- the accumulator stays at zero while disabled;
- the active increment is never zero.

Only the bench scenarios can show the observable timing. They measure period lengths and high times against the programmed values, and they confirm that staged-only writes leave the output alone. They also check that a fresh start after enable reaches its first high clock at the predicted count, and that a zero increment runs at the slowest rate.

// File: rtl/pwm_fracgen.sv
module pwm_fracgen #(
  parameter int BW = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        rd_en,
  output logic [31:0] rd_data,
  output logic        pwm_out
);

  localparam int AW  = BW + 8;
  localparam int BHI = BW + 7;

  logic          en_r, req_r, err_r, was_en;
  logic [BW-1:0] stg_base, act_base;
  logic [7:0]    stg_div, act_div;
  logic [AW-1:0] acc;
  logic [AW:0]   sum;
  logic          run, cyc_start, apply, accept, reject;
  logic [7:0]    phase;
  logic          unused_wr;

  assign sum       = {1'b0, acc} + {{(AW+1-BW){1'b0}}, act_base};
  assign run       = en_r & was_en;
  assign cyc_start = en_r & (~was_en | sum[AW]);
  assign apply     = cyc_start & req_r;
  assign accept    = wr_en & ~req_r;
  assign reject    = wr_en & req_r;
  assign phase     = acc[AW-1:BW];
  assign pwm_out   = run & (phase >= act_div);
  assign unused_wr = ^wr_data[29:BHI+1];

  always_comb begin
    rd_data        = '0;
    rd_data[31]    = en_r;
    rd_data[30]    = req_r;
    rd_data[29]    = err_r;
    rd_data[BHI:8] = stg_base;
    rd_data[7:0]   = stg_div;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_r     <= 1'b0;
      was_en   <= 1'b0;
      req_r    <= 1'b0;
      err_r    <= 1'b0;
      stg_base <= '0;
      stg_div  <= '0;
      act_base <= BW'(1);
      act_div  <= '0;
      acc      <= '0;
    end else begin
      was_en <= en_r;
      if (wr_en) en_r <= wr_data[31];
      acc <= run ? sum[AW-1:0] : '0;

      if (apply)       req_r <= 1'b0;
      else if (accept) req_r <= wr_data[30];

      if (accept) begin
        stg_base <= wr_data[BHI:8];
        stg_div  <= wr_data[7:0];
      end

      if (apply) begin
        act_base <= (stg_base == '0) ? BW'(1) : stg_base;
        act_div  <= stg_div;
      end

      if (reject)     err_r <= 1'b1;
      else if (rd_en) err_r <= 1'b0;
    end
  end

  // R5
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cyc_start && req_r) |=> $stable(act_div) && $stable(act_base));

  // R6
  update_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && req_r) |=> !req_r && act_div == $past(stg_div));

  // R7
  reject_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && req_r) |=> $stable(stg_div) && $stable(stg_base) && req_r && err_r);

  // R8
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !(wr_en && req_r)) |=> !err_r);

  // R9
  idle_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_r && $past(!en_r)) |-> (acc == '0) && !pwm_out);

  // R10
  nonzero_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_base != '0);

endmodule

// File: tb/test_pwm_fracgen.sv
`timescale 1ns/1ps
module test_pwm_fracgen;
  localparam int BW = 10;
  localparam int AW = BW + 8;

  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        pwm_out;

  pwm_fracgen #(.BW(BW)) i_pwm_fracgen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .pwm_out(pwm_out));

  always #2.5 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 1'b0;
  typedef struct { int per; int hi; } item_t;
  item_t q[$];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic en, input logic req, input int base, input int dv);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = '0;
    wr_data[31] = en;
    wr_data[30] = req;
    wr_data[8 +: BW] = base[BW-1:0];
    wr_data[7:0] = dv[7:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(output logic [31:0] v);
    @(negedge clk);
    rd_en = 1'b1;
    v = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic poll(input string tag);
    logic [31:0] v;
    int n = 0;
    do begin rd(v); n++; end while (v[30] && n < 5000);
    chk(v[30] == 1'b0, tag, v[30], 0);
  endtask

  task automatic push(input int base, input int dv);
    item_t it;
    it.per = (1 << AW) / base;
    it.hi  = it.per * (256 - dv) / 256;
    q.push_back(it);
    while (q.size() > 0) @(negedge clk);
  endtask

  task automatic wait_fall();
    logic p = pwm_out;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (p && !pwm_out) break;
      p = pwm_out;
    end
  endtask

  task automatic count_rise(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!pwm_out && n < 5000);
  endtask

  // monitor: measure falling-edge to falling-edge periods and compare with the queue
  logic mprev = 1'b0;
  bit   meas = 1'b0;
  int   per = 0, hi = 0;
  always @(negedge clk) begin
    if (q.size() == 0) meas = 1'b0;
    else if (mprev && !pwm_out) begin
      if (meas) begin
        chk(per == q[0].per, "R3 period", per, q[0].per);
        chk(hi == q[0].hi, "R4 high time", hi, q[0].hi);
        void'(q.pop_front());
      end
      meas = 1'b1;
      per = 0;
      hi = 0;
    end
    if (meas) begin
      per++;
      if (pwm_out) hi++;
    end
    mprev = pwm_out;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n, hcount;
    repeat (5) @(negedge clk);
    chk(rd_data == 32'd0, "R1 reset register", rd_data, 0);
    chk(pwm_out == 1'b0, "R1 reset output", pwm_out, 0);
    rst_n = 1'b1;

    wr(1, 1, 512, 128);
    poll("R6 request clears");
    rd(v);
    chk(v[31] == 1'b1 && v[8 +: BW] == 512 && v[7:0] == 128, "R2 readback", v, 32'h8000_0000 | (512 << 8) | 128);
    push(512, 128);

    wait_fall();
    wr(1, 1, 256, 64);
    rd(v);
    chk(v[30] == 1'b1, "R6 request pending", v[30], 1);
    poll("R6 request clears");
    push(256, 64);

    wr(1, 0, 128, 200);
    rd(v);
    chk(v[8 +: BW] == 128 && v[7:0] == 200 && v[30] == 1'b0, "R5 staged only", v, (128 << 8) | 200 | 32'h8000_0000);
    push(256, 64);
    wr(1, 1, 128, 200);
    poll("R6 request clears");
    push(128, 200);

    wr(1, 1, 512, 255);
    poll("R6 request clears");
    push(512, 255);

    wr(1, 1, 512, 0);
    poll("R6 request clears");
    hcount = 0;
    for (int i = 0; i < 600; i++) begin @(negedge clk); if (pwm_out) hcount++; end
    chk(hcount == 600, "R4 threshold zero always high", hcount, 600);

    wr(1, 1, 512, 100);
    poll("R6 request clears");
    push(512, 100);
    wait_fall();
    wr(1, 1, 256, 50);
    wr(1, 1, 128, 7);
    rd(v);
    chk(v[29] == 1'b1 && v[30] == 1'b1, "R7 error flag", v[30:29], 3);
    chk(v[8 +: BW] == 256 && v[7:0] == 50, "R7 fields kept", {v[8 +: BW], v[7:0]}, (256 << 8) | 50);
    rd(v);
    chk(v[29] == 1'b0, "R8 error cleared by read", v[29], 0);
    poll("R7 update still completes");
    push(256, 50);

    wr(0, 0, 256, 50);
    repeat (3) @(negedge clk);
    hcount = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (pwm_out) hcount++; end
    chk(hcount == 0, "R9 disabled output low", hcount, 0);
    wr(0, 1, 512, 40);
    repeat (50) @(negedge clk);
    rd(v);
    chk(v[30] == 1'b1, "R9 pending held while disabled", v[30], 1);
    wr(1, 0, 512, 40);
    count_rise(n);
    chk(n == 81, "R9 fresh start first high", n, 81);
    rd(v);
    chk(v[30] == 1'b0, "R9 enable applies update", v[30], 0);
    push(512, 40);

    wr(0, 0, 512, 40);
    wr(0, 1, 0, 1);
    rd(v);
    chk(v[8 +: BW] == 0 && v[7:0] == 1, "R10 staged zero readback", v[8 +: BW], 0);
    wr(1, 0, 0, 1);
    count_rise(n);
    chk(n == 1025, "R10 zero increment runs as one", n, 1025);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule